// File: doc/BRIEF.md
# Interrupt Master Gate and Dispatcher

This block sits beside the instruction sequencer of a small 8-bit processor core and decides, at every instruction boundary, whether the core fetches its next opcode or enters an interrupt. It holds the global interrupt enable bit, an 8-bit enable mask and an 8-bit request register. The pending set is the bitwise AND of mask and requests. When the global enable is on and the pending set is non-zero, the lowest-numbered pending source wins. Its request bit is cleared, the global enable drops, and a fixed call address goes to a separate stack-push sequencer.

The enable instruction does not take effect at once. Executing it forces the global enable low and arms a pending toggle. The toggle is applied at the following instruction boundary, so the next instruction always runs before any interrupt can be taken. A mode input makes the disable instruction use the same delayed path. With the mode low, the disable instruction clears the global enable immediately.

All decisions are registered. `fetchGo` or `dispStart` pulses for one cycle, one cycle after the boundary strobe. The call address and the winner index are valid in the same cycle as `dispStart` and hold afterwards.

Top module: `irq_master_gate`

## Requirements
- R1: While reset is asserted and in the cycle after, the global enable, the mask, the request register, `fetchGo` and `dispStart` all read zero.
- R2: An `eiExec` pulse makes `imeOut` 0 in the next cycle. The next boundary then produces `fetchGo`, never `dispStart`, even if interrupts are pending. After that boundary `imeOut` reads 1.
- R3: With `delayedDi` low, a `diExec` pulse makes `imeOut` 0 in the next cycle.
- R4: With `delayedDi` high, a `diExec` pulse leaves `imeOut` unchanged until the next boundary. That boundary may still dispatch, and after it `imeOut` reads 0. A delayed disable that follows an enable, with no boundary in between, leaves `imeOut` at 0 after the next boundary.
- R5: A boundary dispatches only if `imeOut` is 1 in the boundary cycle and (mask AND requests) is non-zero. Otherwise it produces `fetchGo`.
- R6: Among pending sources, the lowest bit index wins.
- R7: `dispStart` pulses in the cycle after the deciding boundary. In that same cycle `dispIndex` holds the winner index and `dispVector` holds 0x0040 + 8 × index as a 16-bit address.
- R8: A dispatch clears the winning request bit and sets `imeOut` to 0. It also discards any pending toggle, so a following boundary leaves `imeOut` at 0.
- R9: `fetchGo` and `dispStart` are never high together. Each is high only in the cycle after a boundary strobe.
- R10: A mask write stores all 8 bits unmasked. `enRdData` shows the written value from the next cycle on.
- R11: A request-register write replaces its contents. `flagSet` bits are ORed in, and in the same cycle they take precedence over a write or a dispatch clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction boundary strobe |
| eiExec | input | 1 | Enable instruction executed |
| diExec | input | 1 | Disable instruction executed |
| delayedDi | input | 1 | 1: disable uses the delayed toggle path |
| enWrEn | input | 1 | Mask register write strobe |
| enWrData | input | 8 | Mask write value |
| enRdData | output | 8 | Mask register contents |
| flagWrEn | input | 1 | Request register write strobe |
| flagWrData | input | 8 | Request write value |
| flagSet | input | 8 | Per-source request set pulses |
| flagRdData | output | 8 | Request register contents |
| imeOut | output | 1 | Global interrupt enable |
| fetchGo | output | 1 | Fetch the next opcode |
| dispStart | output | 1 | Start interrupt entry |
| dispIndex | output | 3 | Winning source index |
| dispVector | output | 16 | Call address for the push sequencer |

## Verification
The hardest state to reach is a boundary where a toggle is pending while the global enable is already 1. Only a delayed disable that follows a completed enable sequence produces it. The bench reaches it by running an enable and a fetch boundary, switching the mode high and issuing a disable. It then checks that the pending interrupt is still taken and that the discarded toggle does not turn the enable back on at the next boundary. Separate sweeps run all 256 request patterns under a full mask and all 256 masks under full requests to cover the priority logic.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef struct packed {
    logic applyToggle;
    logic doDispatch;
    logic doFetch;
    logic setEi;
    logic clearNow;
    logic deferDi;
  } gateStrobe_t;

endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
(
  input  logic        boundary,
  input  logic        eiExec,
  input  logic        diExec,
  input  logic        delayedDi,
  input  logic        imeQ,
  input  logic        toggleQ,
  input  logic        anyPending,
  output gateStrobe_t strobes
);

  always_comb begin
    strobes             = '0;
    // the pending toggle is applied at the boundary, but the dispatch
    // decision uses the enable value held before that boundary
    strobes.applyToggle = boundary & toggleQ;
    strobes.doDispatch  = boundary & imeQ & anyPending;
    strobes.doFetch     = boundary & ~strobes.doDispatch;
    // enable wins over a simultaneous disable
    strobes.setEi       = eiExec;
    strobes.clearNow    = diExec & ~eiExec & ~delayedDi;
    strobes.deferDi     = diExec & ~eiExec & delayedDi;
  end

endmodule

// File: rtl/irq_gate_dpath.sv
module irq_gate_dpath
  import irq_gate_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W     = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  gateStrobe_t       strobes,
  input  logic              enWrEn,
  input  logic [REG_W-1:0]  enWrData,
  input  logic              flagWrEn,
  input  logic [REG_W-1:0]  flagWrData,
  input  logic [REG_W-1:0]  flagSet,
  output logic [REG_W-1:0]  enQ,
  output logic [REG_W-1:0]  flagQ,
  output logic              imeQ,
  output logic              toggleQ,
  output logic              anyPending,
  output logic              fetchGo,
  output logic              dispStart,
  output logic [IDX_W-1:0]  dispIndex,
  output logic [ADDR_W-1:0] dispVector
);

  logic [REG_W-1:0]  pendSet;
  logic [IDX_W-1:0]  winIdx;
  logic [REG_W-1:0]  winMask;
  logic [ADDR_W-1:0] winVector;
  logic              imeN;
  logic              toggleN;

  assign pendSet    = enQ & flagQ;
  assign anyPending = |pendSet;

  // lowest index has priority: scan from the top so the lowest hit is last
  always_comb begin
    winIdx = '0;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (pendSet[i]) winIdx = IDX_W'(i);
    end
  end

  assign winVector = ADDR_W'(VEC_BASE) + ADDR_W'(winIdx) * ADDR_W'(VEC_STRIDE);

  // per-source request bits
  genvar b;
  generate
    for (b = 0; b < REG_W; b++) begin : g_flag
      assign winMask[b] = strobes.doDispatch && (winIdx == IDX_W'(b));
      always_ff @(posedge clk) begin
        if (rst) begin
          flagQ[b] <= 1'b0;
        end else if (flagSet[b]) begin
          flagQ[b] <= 1'b1;
        end else if (winMask[b]) begin
          flagQ[b] <= 1'b0;
        end else if (flagWrEn) begin
          flagQ[b] <= flagWrData[b];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ <= '0;
    end else if (enWrEn) begin
      enQ <= enWrData;
    end
  end

  // global enable and pending toggle
  always_comb begin
    imeN    = imeQ;
    toggleN = toggleQ;
    if (strobes.applyToggle) begin
      imeN    = ~imeQ;
      toggleN = 1'b0;
    end
    if (strobes.doDispatch) begin
      imeN    = 1'b0;
      toggleN = 1'b0;
    end
    if (strobes.setEi) begin
      imeN    = 1'b0;
      toggleN = 1'b1;
    end else if (strobes.clearNow) begin
      imeN    = 1'b0;
    end else if (strobes.deferDi) begin
      // arm a flip only if the enable would otherwise still be on
      toggleN = imeN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imeQ    <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      imeQ    <= imeN;
      toggleQ <= toggleN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchGo    <= 1'b0;
      dispStart  <= 1'b0;
      dispIndex  <= '0;
      dispVector <= '0;
    end else begin
      fetchGo   <= strobes.doFetch;
      dispStart <= strobes.doDispatch;
      if (strobes.doDispatch) begin
        dispIndex  <= winIdx;
        dispVector <= winVector;
      end
    end
  end

endmodule

// File: rtl/irq_master_gate.sv
module irq_master_gate
  import irq_gate_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W     = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              eiExec,
  input  logic              diExec,
  input  logic              delayedDi,
  input  logic              enWrEn,
  input  logic [REG_W-1:0]  enWrData,
  output logic [REG_W-1:0]  enRdData,
  input  logic              flagWrEn,
  input  logic [REG_W-1:0]  flagWrData,
  input  logic [REG_W-1:0]  flagSet,
  output logic [REG_W-1:0]  flagRdData,
  output logic              imeOut,
  output logic              fetchGo,
  output logic              dispStart,
  output logic [IDX_W-1:0]  dispIndex,
  output logic [ADDR_W-1:0] dispVector
);

  gateStrobe_t strobes;
  logic        imeQ;
  logic        toggleQ;
  logic        anyPending;

  irq_gate_ctrl u_ctrl (
    .boundary   (boundary),
    .eiExec     (eiExec),
    .diExec     (diExec),
    .delayedDi  (delayedDi),
    .imeQ       (imeQ),
    .toggleQ    (toggleQ),
    .anyPending (anyPending),
    .strobes    (strobes)
  );

  irq_gate_dpath #(
    .REG_W      (REG_W),
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .enWrEn     (enWrEn),
    .enWrData   (enWrData),
    .flagWrEn   (flagWrEn),
    .flagWrData (flagWrData),
    .flagSet    (flagSet),
    .enQ        (enRdData),
    .flagQ      (flagRdData),
    .imeQ       (imeQ),
    .toggleQ    (toggleQ),
    .anyPending (anyPending),
    .fetchGo    (fetchGo),
    .dispStart  (dispStart),
    .dispIndex  (dispIndex),
    .dispVector (dispVector)
  );

  assign imeOut = imeQ;

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int REG_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W     = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              boundary,
  input logic              eiExec,
  input logic              diExec,
  input logic              delayedDi,
  input logic              enWrEn,
  input logic [REG_W-1:0]  enWrData,
  input logic [REG_W-1:0]  enRdData,
  input logic              flagWrEn,
  input logic [REG_W-1:0]  flagSet,
  input logic [REG_W-1:0]  flagRdData,
  input logic              imeOut,
  input logic              fetchGo,
  input logic              dispStart,
  input logic [IDX_W-1:0]  dispIndex,
  input logic [ADDR_W-1:0] dispVector
);

  // R2
  ei_clears_ime_chk: assert property (@(posedge clk) disable iff (rst)
    eiExec |=> !imeOut);

  // R3
  di_basic_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (diExec && !delayedDi && !eiExec) |=> !imeOut);

  // R4
  di_delayed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (diExec && delayedDi && !eiExec && !boundary) |=> (imeOut == $past(imeOut)));

  // R5
  dispatch_needs_ime_chk: assert property (@(posedge clk) disable iff (rst)
    dispStart |-> $past(imeOut));

  // R5
  no_dispatch_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && !imeOut) |=> !dispStart);

  // R7
  vector_matches_index_chk: assert property (@(posedge clk) disable iff (rst)
    dispStart |-> (dispVector == ADDR_W'(VEC_BASE) + ADDR_W'(dispIndex) * ADDR_W'(VEC_STRIDE)));

  // R8
  dispatch_drops_ime_chk: assert property (@(posedge clk) disable iff (rst)
    dispStart |-> !imeOut);

  // R8
  winner_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (dispStart && ($past(flagSet) == '0) && !$past(flagWrEn)) |-> !flagRdData[dispIndex]);

  // R9
  exclusive_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetchGo, dispStart}));

  // R9
  outcome_after_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (fetchGo || dispStart) |-> $past(boundary));

  // R10
  mask_readback_chk: assert property (@(posedge clk) disable iff (rst)
    enWrEn |=> (enRdData == $past(enWrData)));

endmodule

bind irq_master_gate irq_gate_chk #(
  .REG_W      (REG_W),
  .ADDR_W     (ADDR_W),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .boundary   (boundary),
  .eiExec     (eiExec),
  .diExec     (diExec),
  .delayedDi  (delayedDi),
  .enWrEn     (enWrEn),
  .enWrData   (enWrData),
  .enRdData   (enRdData),
  .flagWrEn   (flagWrEn),
  .flagSet    (flagSet),
  .flagRdData (flagRdData),
  .imeOut     (imeOut),
  .fetchGo    (fetchGo),
  .dispStart  (dispStart),
  .dispIndex  (dispIndex),
  .dispVector (dispVector)
);

// File: tb/irq_master_gate_tb.sv
module irq_master_gate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boundary = 1'b0;
  logic        eiExec = 1'b0;
  logic        diExec = 1'b0;
  logic        delayedDi = 1'b0;
  logic        enWrEn = 1'b0;
  logic [7:0]  enWrData = '0;
  logic [7:0]  enRdData;
  logic        flagWrEn = 1'b0;
  logic [7:0]  flagWrData = '0;
  logic [7:0]  flagSet = '0;
  logic [7:0]  flagRdData;
  logic        imeOut;
  logic        fetchGo;
  logic        dispStart;
  logic [2:0]  dispIndex;
  logic [15:0] dispVector;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  irq_master_gate u_dut (
    .clk(clk), .rst(rst), .boundary(boundary), .eiExec(eiExec), .diExec(diExec),
    .delayedDi(delayedDi), .enWrEn(enWrEn), .enWrData(enWrData), .enRdData(enRdData),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .flagSet(flagSet),
    .flagRdData(flagRdData), .imeOut(imeOut), .fetchGo(fetchGo),
    .dispStart(dispStart), .dispIndex(dispIndex), .dispVector(dispVector)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowestBit(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) ;
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulseBoundary();
    boundary = 1'b1; step(); boundary = 1'b0;
  endtask

  task automatic pulseEi();
    eiExec = 1'b1; step(); eiExec = 1'b0;
  endtask

  task automatic pulseDi();
    diExec = 1'b1; step(); diExec = 1'b0;
  endtask

  task automatic writeMask(input logic [7:0] v);
    enWrEn = 1'b1; enWrData = v; step(); enWrEn = 1'b0;
  endtask

  task automatic writeFlags(input logic [7:0] v);
    flagWrEn = 1'b1; flagWrData = v; step(); flagWrEn = 1'b0;
  endtask

  // EI then a boundary (no dispatch possible), leaving the enable on
  task automatic turnOn();
    pulseEi();
    pulseBoundary();
  endtask

  task automatic sweepCase(input string tag, input logic [7:0] mask, input logic [7:0] req);
    int w;
    w = lowestBit(mask & req);
    writeMask(mask);
    writeFlags(req);
    turnOn();
    pulseBoundary();
    if (w < 0) begin
      check({tag, " R5 fetch"}, int'(fetchGo), 1);
      check({tag, " R5 no dispatch"}, int'(dispStart), 0);
      check({tag, " R5 ime kept"}, int'(imeOut), 1);
    end else begin
      check({tag, " R6 dispatch"}, int'(dispStart), 1);
      check({tag, " R6 index"}, int'(dispIndex), w);
      check({tag, " R7 vector"}, int'(dispVector), 'h40 + 8 * w);
      check({tag, " R8 flag cleared"}, int'(flagRdData), int'(req & ~(8'(1) << w)));
      check({tag, " R8 ime off"}, int'(imeOut), 0);
      check({tag, " R9 no fetch"}, int'(fetchGo), 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    check("R1 ime", int'(imeOut), 0);
    check("R1 mask", int'(enRdData), 0);
    check("R1 flags", int'(flagRdData), 0);
    check("R1 fetch", int'(fetchGo), 0);
    check("R1 dispatch", int'(dispStart), 0);
    rst = 1'b0;
    step();
    check("R1 after release", int'(imeOut), 0);

    // R10 mask readback
    writeMask(8'hA5);
    check("R10 mask", int'(enRdData), 'hA5);
    writeMask(8'hE0);
    check("R10 upper bits kept", int'(enRdData), 'hE0);

    // R11 request register
    writeFlags(8'h3C);
    check("R11 write", int'(flagRdData), 'h3C);
    flagSet = 8'h01; step(); flagSet = '0;
    check("R11 set ors", int'(flagRdData), 'h3D);
    flagWrEn = 1'b1; flagWrData = 8'h00; flagSet = 8'h80; step();
    flagWrEn = 1'b0; flagSet = '0;
    check("R11 set beats write", int'(flagRdData), 'h80);

    // R2 EI delay: pending interrupt, EI, first boundary must fetch
    writeMask(8'hFF);
    writeFlags(8'h04);
    pulseEi();
    check("R2 ime low after ei", int'(imeOut), 0);
    pulseBoundary();
    check("R2 first boundary fetches", int'(fetchGo), 1);
    check("R2 no early dispatch", int'(dispStart), 0);
    check("R2 ime on after boundary", int'(imeOut), 1);
    pulseBoundary();
    check("R2 second boundary dispatch", int'(dispStart), 1);
    check("R2 index", int'(dispIndex), 2);

    // R3 basic disable is immediate
    writeFlags(8'h00);
    delayedDi = 1'b0;
    turnOn();
    check("R3 ime on", int'(imeOut), 1);
    pulseDi();
    check("R3 ime off at once", int'(imeOut), 0);
    writeFlags(8'h10);
    pulseBoundary();
    check("R5 off blocks dispatch", int'(dispStart), 0);
    check("R5 off fetches", int'(fetchGo), 1);

    // R4 delayed disable: still on, boundary can dispatch, toggle discarded
    writeFlags(8'h00);
    turnOn();
    delayedDi = 1'b1;
    pulseDi();
    check("R4 ime held", int'(imeOut), 1);
    writeFlags(8'h20);
    pulseBoundary();
    check("R4 dispatch still taken", int'(dispStart), 1);
    check("R4 index", int'(dispIndex), 5);
    check("R8 ime off after dispatch", int'(imeOut), 0);
    pulseBoundary();
    check("R8 toggle discarded", int'(imeOut), 0);

    // R4 delayed disable without pending: boundary turns ime off
    writeFlags(8'h00);
    turnOn();
    pulseDi();
    check("R4 held before boundary", int'(imeOut), 1);
    pulseBoundary();
    check("R4 off after boundary", int'(imeOut), 0);
    check("R4 fetch", int'(fetchGo), 1);

    // R4 delayed disable cancels a pending enable
    pulseEi();
    pulseDi();
    pulseBoundary();
    check("R4 ei then di stays off", int'(imeOut), 0);
    pulseBoundary();
    check("R4 stays off", int'(imeOut), 0);
    delayedDi = 1'b0;

    // R6 R7 sweep of every request pattern under a full mask
    for (int k = 0; k < 256; k++) sweepCase("req sweep", 8'hFF, 8'(k));
    // R6 R5 sweep of every mask under full requests
    for (int m = 0; m < 256; m++) sweepCase("mask sweep", 8'(m), 8'hFF);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule